// File: doc/BRIEF.md
# Shared-Adder Four-Operation ALU

This block is a purely combinational arithmetic unit. It computes one of four functions of two operands: the two's-complement negation of B, A minus B, A plus B, or the bitwise exclusive-OR of A and B. A 2-bit operation code picks the function. All four functions come from one ripple chain of full-adder bit slices. No function has a unit of its own.

Each operation is made by steering the chain:

- The A operand is gated to zero for negation.
- The B operand is inverted for the two subtracting codes, and the chain carry-in is raised at the same time.
- Every carry between slices is cut for the exclusive-OR code, so each slice leaves only its sum bit.

The outputs are the result vector, the carry leaving the top slice, and a flag that is high when the result is all zeros. The operand width is a parameter with a default of 8 bits. The outputs settle from the inputs alone, with no clock.

Top module: `shared_adder_alu`

## Requirements
- R1: With op_code 2'b00 the result is (0 - opb) modulo 2^WIDTH, and carry_out is 1 exactly when opb is zero.
- R2: With op_code 2'b01 the result is (opa - opb) modulo 2^WIDTH, and carry_out is 1 exactly when opa is not less than opb as unsigned values.
- R3: With op_code 2'b10 the result is the low WIDTH bits of opa + opb, and carry_out is bit WIDTH of that unsigned sum.
- R4: With op_code 2'b11 the result is opa XOR opb, and carry_out is 0 whatever the operands.
- R5: zero_flag is 1 exactly when every bit of result is 0, for every op_code.
- R6: Negating zero gives result 0 with carry_out 1 and zero_flag 1. Negating the most negative value (only the top bit set) gives that same value back, with carry_out 0 and zero_flag 0.
- R7: The outputs follow the present inputs alone. A change of opa, opb or op_code is visible at the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| op_code | input | 2 | Operation: 00 negate B, 01 A-B, 10 A+B, 11 A XOR B |
| result | output | WIDTH | Selected function of the operands |
| carry_out | output | 1 | Carry leaving the most significant slice; 0 for XOR |
| zero_flag | output | 1 | High when result is all zeros |

## Verification
The block holds no state, so a wrong steering signal shows at the ports in the same evaluation as the inputs that exercise it:

- An A gate left open corrupts negation for any nonzero opa.
- A missing carry-in shifts every difference by one.
- A carry chain that is not cut leaks carries into the XOR result wherever both operands have a 1 in the same bit.

An exhaustive sweep of every operand pair and every code at a 4-bit width therefore exposes any such fault right away. That includes the zero and most-negative corners of negation.

// File: rtl/alu_pkg.sv
// Package: shared definitions for the shared-adder ALU.
// Assumes: operation codes are 2 bits wide and fixed in value.
package alu_pkg;

    typedef enum logic [1:0] {
        OP_NEG = 2'b00,
        OP_SUB = 2'b01,
        OP_ADD = 2'b10,
        OP_XOR = 2'b11
    } alu_op_e;

    localparam int OP_BITS = 2;

endpackage

// File: rtl/alu_operand_steer.sv
// Module: alu_operand_steer
// Derives the adder operands, the chain carry-in and the carry-enable from the
// operation code. Assumes op_code bit 1 selects add-type versus subtract-type.
module alu_operand_steer #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [1:0]       op_code,
    output logic [WIDTH-1:0] a_eff,
    output logic [WIDTH-1:0] b_eff,
    output logic             carry_in,
    output logic             chain_en
);

    logic pass_a;
    logic invert_b;

    // Purpose: decode the control bits that steer the shared chain.
    always_comb begin
        pass_a   = op_code[1] | op_code[0];
        invert_b = ~op_code[1];
        chain_en = ~(op_code[1] & op_code[0]);
        carry_in = invert_b;
    end

    // Purpose: gate A to zero for negation and conditionally invert B.
    always_comb begin
        a_eff = a_in & {WIDTH{pass_a}};
        b_eff = b_in ^ {WIDTH{invert_b}};
    end

    // A gated to zero means negation; only code 00 may do that.
    always_comb begin
        if (!$isunknown({a_in, op_code}))
            AST_A_GATED_ONLY_NEG: assert final ((op_code == 2'b00) || (a_eff == a_in)); // R1
    end

endmodule

// File: rtl/alu_bit_slice.sv
// Module: alu_bit_slice
// One full-adder slice of the shared chain. Assumes single-bit operands.
module alu_bit_slice (
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_in,
    output logic s_bit,
    output logic c_out
);

    // Purpose: full-adder sum and carry.
    always_comb begin
        s_bit = a_bit ^ b_bit ^ c_in;
        c_out = (a_bit & b_bit) | (c_in & (a_bit ^ b_bit));
    end

endmodule

// File: rtl/alu_ripple_chain.sv
// Module: alu_ripple_chain
// Ripple chain of WIDTH slices. Each inter-slice carry, and the final carry,
// passes through an AND gate held open by chain_en. Assumes carry_in is 0
// whenever chain_en is low.
module alu_ripple_chain #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_eff,
    input  logic [WIDTH-1:0] b_eff,
    input  logic             carry_in,
    input  logic             chain_en,
    output logic [WIDTH-1:0] sum,
    output logic             carry_last
);

    logic [WIDTH:0]   carry_link;
    logic [WIDTH-1:0] raw_carry;

    assign carry_link[0] = carry_in;

    generate
        for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
            alu_bit_slice u_slice (
                .a_bit (a_eff[gi]),
                .b_bit (b_eff[gi]),
                .c_in  (carry_link[gi]),
                .s_bit (sum[gi]),
                .c_out (raw_carry[gi])
            );
            // Purpose: cut the carry leaving this slice when the chain is broken.
            assign carry_link[gi+1] = raw_carry[gi] & chain_en;
        end
    endgenerate

    assign carry_last = carry_link[WIDTH];

    // With the chain cut, every slice must leave a carry-less sum.
    always_comb begin
        if (!$isunknown({a_eff, b_eff, carry_in, chain_en}))
            AST_BROKEN_CHAIN_XOR: assert final (chain_en || (sum == (a_eff ^ b_eff))); // R4
    end

endmodule

// File: rtl/alu_flags.sv
// Module: alu_flags
// Zero detection on the result vector. Assumes result is fully settled.
module alu_flags #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] result,
    output logic             zero_flag
);

    // Purpose: NOR-reduce the result bits.
    always_comb begin
        zero_flag = ~(|result);
    end

endmodule

// File: rtl/shared_adder_alu.sv
// Module: shared_adder_alu
// Four-operation ALU built on one ripple adder chain. Negation, subtraction,
// addition and XOR are produced by steering operands, carry-in and the
// inter-slice carries. Assumes WIDTH >= 2; purely combinational, no reset.
module shared_adder_alu #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [1:0]       op_code,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             zero_flag
);

    localparam int SUM_W = WIDTH + 1;

    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;
    logic             carry_in;
    logic             chain_en;
    logic [WIDTH-1:0] chain_sum;
    logic             chain_carry;

    alu_operand_steer #(.WIDTH(WIDTH)) u_steer (
        .a_in     (opa),
        .b_in     (opb),
        .op_code  (op_code),
        .a_eff    (a_eff),
        .b_eff    (b_eff),
        .carry_in (carry_in),
        .chain_en (chain_en)
    );

    alu_ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .a_eff      (a_eff),
        .b_eff      (b_eff),
        .carry_in   (carry_in),
        .chain_en   (chain_en),
        .sum        (chain_sum),
        .carry_last (chain_carry)
    );

    // Purpose: drive the result ports from the shared chain.
    always_comb begin
        result    = chain_sum;
        carry_out = chain_carry;
    end

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .result    (chain_sum),
        .zero_flag (zero_flag)
    );

    // Port-level checks against arithmetic references.
    logic [SUM_W-1:0] ref_add;
    always_comb ref_add = {1'b0, opa} + {1'b0, opb};

    always_comb begin
        if (!$isunknown({opa, opb, op_code})) begin
            AST_NEG_VALUE: assert final ((op_code != 2'b00) || (result == WIDTH'(-opb))); // R1
            AST_SUB_VALUE: assert final ((op_code != 2'b01) || ((result == WIDTH'(opa - opb)) && (carry_out == (opa >= opb)))); // R2
            AST_ADD_VALUE: assert final ((op_code != 2'b10) || ({carry_out, result} == ref_add)); // R3
            AST_XOR_NO_CARRY: assert final ((op_code != 2'b11) || ((result == (opa ^ opb)) && !carry_out)); // R4
            AST_ZERO_MATCH: assert final (zero_flag == (result == '0)); // R5
        end
    end

endmodule

// File: tb/shared_adder_alu_tb_top.sv
// Bench: scoreboard for shared_adder_alu at WIDTH 4, exhaustive sweep.
module shared_adder_alu_tb_top;

    localparam int W          = 4;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [1:0]   op;
        logic [W-1:0] exp_r;
        logic         exp_c;
        logic         exp_z;
        string        tag;
    } item_t;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic [1:0]   op_code;
    logic [W-1:0] result;
    logic         carry_out;
    logic         zero_flag;

    int checks;
    int fails;
    item_t sb_q[$];
    bit    drive_done;

    shared_adder_alu #(.WIDTH(W)) dut_i (
        .opa       (opa),
        .opb       (opb),
        .op_code   (op_code),
        .result    (result),
        .carry_out (carry_out),
        .zero_flag (zero_flag)
    );

    // Purpose: free-running bench clock.
    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Purpose: build the expected item from the requirements alone.
    function automatic item_t expect_of(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] op);
        item_t it;
        it.a = a; it.b = b; it.op = op;
        case (op)
            2'b00: begin it.exp_r = W'((1 << W) - int'(b)); it.exp_c = (b == 0); it.tag = "R1"; end
            2'b01: begin it.exp_r = W'(int'(a) - int'(b)); it.exp_c = (a >= b); it.tag = "R2"; end
            2'b10: begin it.exp_r = W'(int'(a) + int'(b)); it.exp_c = ((int'(a) + int'(b)) >= (1 << W)); it.tag = "R3"; end
            default: begin it.exp_r = a ^ b; it.exp_c = 1'b0; it.tag = "R4"; end
        endcase
        it.exp_z = (it.exp_r == 0);
        return it;
    endfunction

    // Purpose: one compare with counting and a FAIL line on mismatch.
    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Purpose: driver - apply stimulus after a rising edge and push expectation.
    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] op, string tag);
        item_t it;
        @(posedge clk);
        #1;
        opa = a; opb = b; op_code = op;
        it = expect_of(a, b, op);
        if (tag != "") it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Purpose: monitor - pop and compare at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, "result", int'(result), int'(it.exp_r));
                check(it.tag, "carry_out", int'(carry_out), int'(it.exp_c));
                check("R5", "zero_flag", int'(zero_flag), int'(it.exp_z));
            end
        end
    end

    // Purpose: watchdog that ends a hung run as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Purpose: main sequence.
    initial begin
        checks = 0; fails = 0; drive_done = 0;
        rst_n = 1'b0;
        opa = '0; opb = '0; op_code = 2'b00;
        repeat (2) @(posedge clk);
        #2;
        // Reset state: negating zero with zero inputs (R6).
        check("R6", "reset result", int'(result), 0);
        check("R6", "reset carry_out", int'(carry_out), 1);
        check("R6", "reset zero_flag", int'(zero_flag), 1);
        rst_n = 1'b1;

        // R6 corners: negate zero and the most negative value.
        drive('0, '0, 2'b00, "R6");
        drive(4'h5, {1'b1, {(W-1){1'b0}}}, 2'b00, "R6");

        // R7: inputs changed between edges, outputs follow with no clock.
        @(posedge clk);
        #1;
        opa = 4'h9; opb = 4'h3; op_code = 2'b10;
        #1;
        check("R7", "add no clock", int'(result), 12);
        op_code = 2'b11;
        #1;
        check("R7", "xor no clock", int'(result), 10);
        opb = 4'h9;
        #1;
        check("R7", "zero no clock", int'(zero_flag), 1);

        // Exhaustive sweep of codes and operands (R1-R5 by tag per code).
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < (1 << W); a++)
                for (int b = 0; b < (1 << W); b++)
                    drive(W'(a), W'(b), 2'(op), "");

        repeat (3) @(posedge clk);
        drive_done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule